// File: doc/BRIEF.md
# Vector Upper-Half Transition Controller

This block tracks whether the upper 128-bit halves of sixteen vector registers are known zero, live under wide code, or parked while narrow code from an older encoding runs. Each issued instruction presents a class and a speculative flag on a valid/ready port. Most changes are free. The two changes that cross between the live and parked conditions start a bulk copy engine, and the scrub that leaves the parked condition starts it as well. The engine moves one register upper per cycle between the external register file and an internal scratchpad, after a fixed setup delay.

The block has three conditions, `state_o` = 0 clean, 1 dirty and 2 saved. The instruction class is on `ins_class`: 0 legacy narrow, 1 prefixed narrow, 2 prefixed wide, 3 zero-uppers, 4 zero-all, 5 state restore. Codes 6 and 7 are accepted and change nothing. Back-pressure works as follows. `ins_ready` is low for the whole of a copy. An instruction is taken on a rising edge where `ins_valid` and `ins_ready` are both high. While `ins_ready` is low, the producer holds its instruction steady, and that instruction takes effect only once the running copy has finished. An instruction flagged speculative is accepted but has no effect.

A copy keeps the port stalled for `OVH + NREG` cycles, 50 with the defaults. Register uppers are moved in ascending index order during the last `NREG` of those cycles. The register file read port is combinational: the block drives `rf_rd_idx`, and `rf_rd_data` must return that register's upper in the same cycle.

Top module: `vu_state_ctrl`

## Requirements
- R1: While and after reset, `state_o` is 0 (clean), `busy` is 0, `ins_ready` is 1 and both event counts are 0.
- R2: In clean, classes 0, 1, 3, 4 and 5 leave the state clean with no stall, and class 2 (prefixed wide) moves to dirty with no stall; clean never goes directly to saved.
- R3: In dirty, classes 3, 4 and 5 return to clean with no stall, and classes 1 and 2 keep dirty with no stall.
- R4: In dirty, class 0 (legacy narrow) moves to saved and holds `busy` high and `ins_ready` low for `OVH+NREG` cycles, during which every register upper 0..NREG-1 is copied into the scratchpad.
- R5: In saved, class 0 keeps saved with no stall.
- R6: In saved, classes 1 or 2 move to dirty with a stall of `OVH+NREG` cycles, writing the parked uppers back to the register file in ascending index order, so the file again holds the values captured on entry to saved.
- R7: In saved, classes 3, 4 or 5 move to clean with a stall of `OVH+NREG` cycles, writing zero to every register upper.
- R8: An accepted instruction with `ins_spec` = 1 changes neither state nor counters and causes no stall.
- R9: `cnt_to_saved` increments by one on each dirty-to-saved change, and `cnt_to_dirty` increments by one on each saved-to-dirty change; neither counter changes at any other time.
- R10: While `busy` is 1, `ins_ready` is 0; an instruction held valid during a copy leaves the state unchanged until it is accepted after the copy ends.
- R11: `rf_wr_en` is asserted only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction class present |
| ins_ready | output | 1 | Block can take an instruction |
| ins_class | input | 3 | Instruction class code |
| ins_spec | input | 1 | Instruction is on a speculative path |
| rf_rd_idx | output | IW | Register whose upper is read |
| rf_rd_data | input | UW | Upper half of the register at `rf_rd_idx` |
| rf_wr_en | output | 1 | Write strobe for a register upper |
| rf_wr_idx | output | IW | Register whose upper is written |
| rf_wr_data | output | UW | Data written to the upper half |
| busy | output | 1 | Copy engine running |
| state_o | output | 2 | Current condition: 0 clean, 1 dirty, 2 saved |
| cnt_to_saved | output | CW | Dirty-to-saved event count |
| cnt_to_dirty | output | CW | Saved-to-dirty event count |

## Verification
The bench targets the asymmetry around the saved condition. A scrub out of saved that skipped the copy would show a zero stall and leave stale uppers behind. A design that allowed clean to jump straight into saved would stall on narrow code in clean. After a park, the bench scrambles its register file model, so a design that restored the wrong entries, or wrote them in the wrong order, produces mismatching uppers. An instruction is held valid across a running copy, which exposes a design that applies it early. Speculative instructions are sent in both dirty and saved, which catches a design that lets them move state or bump a counter.

// File: rtl/vu_pkg.sv
package vu_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_DIRTY = 2'd1,
    ST_SAVED = 2'd2
  } ust_e;

  typedef enum logic [2:0] {
    IC_LEGACY     = 3'd0,
    IC_PFX_NARROW = 3'd1,
    IC_PFX_WIDE   = 3'd2,
    IC_ZERO_UP    = 3'd3,
    IC_ZERO_ALL   = 3'd4,
    IC_RESTORE    = 3'd5
  } icls_e;

  typedef enum logic [1:0] {
    XF_NONE  = 2'd0,
    XF_SAVE  = 2'd1,
    XF_LOAD  = 2'd2,
    XF_SCRUB = 2'd3
  } xfer_e;

  typedef struct packed {
    ust_e  nxt;
    xfer_e xfer;
    logic  inc_saved;
    logic  inc_dirty;
  } decision_t;

  function automatic logic is_zeroing(input logic [2:0] c);
    return (c == IC_ZERO_UP) || (c == IC_ZERO_ALL) || (c == IC_RESTORE);
  endfunction

  function automatic logic is_prefixed(input logic [2:0] c);
    return (c == IC_PFX_NARROW) || (c == IC_PFX_WIDE);
  endfunction

endpackage

// File: rtl/vu_state_fsm.sv
module vu_state_fsm
  import vu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [2:0] cls,
  output ust_e       state,
  output xfer_e      xfer_start,
  output logic       inc_saved,
  output logic       inc_dirty
);

  ust_e      state_q;
  decision_t dec;

  always_comb begin
    dec.nxt       = state_q;
    dec.xfer      = XF_NONE;
    dec.inc_saved = 1'b0;
    dec.inc_dirty = 1'b0;
    unique case (state_q)
      ST_CLEAN: begin
        if (cls == IC_PFX_WIDE) dec.nxt = ST_DIRTY;
      end
      ST_DIRTY: begin
        if (cls == IC_LEGACY) begin
          dec.nxt       = ST_SAVED;
          dec.xfer      = XF_SAVE;
          dec.inc_saved = 1'b1;
        end else if (is_zeroing(cls)) begin
          dec.nxt = ST_CLEAN;
        end
      end
      ST_SAVED: begin
        if (is_prefixed(cls)) begin
          dec.nxt       = ST_DIRTY;
          dec.xfer      = XF_LOAD;
          dec.inc_dirty = 1'b1;
        end else if (is_zeroing(cls)) begin
          dec.nxt  = ST_CLEAN;
          dec.xfer = XF_SCRUB;
        end
      end
      default: dec.nxt = ST_CLEAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CLEAN;
    else if (fire) state_q <= dec.nxt;
  end

  assign state      = state_q;
  assign xfer_start = fire ? dec.xfer : XF_NONE;
  assign inc_saved  = fire && dec.inc_saved;
  assign inc_dirty  = fire && dec.inc_dirty;

endmodule

// File: rtl/vu_copy_engine.sv
module vu_copy_engine
  import vu_pkg::*;
#(
  parameter int NREG = 16,
  parameter int OVH  = 34,
  localparam int IW    = $clog2(NREG),
  localparam int TOTAL = OVH + NREG,
  localparam int CNTW  = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xfer_e         start,
  output logic          busy,
  output xfer_e         kind,
  output logic          moving,
  output logic [IW-1:0] idx
);

  logic            busy_q;
  xfer_e           kind_q;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= XF_NONE;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start != XF_NONE) begin
        busy_q <= 1'b1;
        kind_q <= start;
        cnt_q  <= '0;
      end
    end else begin
      if (cnt_q == CNTW'(TOTAL - 1)) begin
        busy_q <= 1'b0;
        kind_q <= XF_NONE;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign off    = cnt_q - CNTW'(OVH);
  assign busy   = busy_q;
  assign kind   = kind_q;
  assign moving = busy_q && (cnt_q >= CNTW'(OVH));
  assign idx    = off[IW-1:0];

endmodule

// File: rtl/vu_scratchpad.sv
module vu_scratchpad #(
  parameter int NREG = 16,
  parameter int UW   = 128,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [UW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [UW-1:0] rdata
);

  logic [UW-1:0] rows [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_row
    logic [UW-1:0] row_q;
    always_ff @(posedge clk) begin
      if (we && (widx == IW'(g))) row_q <= wdata;
    end
    assign rows[g] = row_q;
  end

  assign rdata = rows[ridx];

endmodule

// File: rtl/vu_event_ctr.sv
module vu_event_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bump,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (bump) count <= count + 1'b1;
  end

endmodule

// File: rtl/vu_state_ctrl.sv
module vu_state_ctrl
  import vu_pkg::*;
#(
  parameter int NREG = 16,
  parameter int UW   = 128,
  parameter int OVH  = 34,
  parameter int CW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [2:0]    ins_class,
  input  logic          ins_spec,
  output logic [IW-1:0] rf_rd_idx,
  input  logic [UW-1:0] rf_rd_data,
  output logic          rf_wr_en,
  output logic [IW-1:0] rf_wr_idx,
  output logic [UW-1:0] rf_wr_data,
  output logic          busy,
  output logic [1:0]    state_o,
  output logic [CW-1:0] cnt_to_saved,
  output logic [CW-1:0] cnt_to_dirty
);

  logic          fire;
  ust_e          state;
  xfer_e         xfer_start;
  xfer_e         kind;
  logic          inc_saved;
  logic          inc_dirty;
  logic          moving;
  logic [IW-1:0] idx;
  logic [UW-1:0] sp_rdata;
  logic          sp_we;

  assign ins_ready = !busy;
  assign fire      = ins_valid && ins_ready && !ins_spec;

  vu_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .cls        (ins_class),
    .state      (state),
    .xfer_start (xfer_start),
    .inc_saved  (inc_saved),
    .inc_dirty  (inc_dirty)
  );

  vu_copy_engine #(.NREG(NREG), .OVH(OVH)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (xfer_start),
    .busy   (busy),
    .kind   (kind),
    .moving (moving),
    .idx    (idx)
  );

  assign sp_we = moving && (kind == XF_SAVE);

  vu_scratchpad #(.NREG(NREG), .UW(UW)) u_sp (
    .clk   (clk),
    .we    (sp_we),
    .widx  (idx),
    .wdata (rf_rd_data),
    .ridx  (idx),
    .rdata (sp_rdata)
  );

  assign rf_rd_idx  = idx;
  assign rf_wr_en   = moving && ((kind == XF_LOAD) || (kind == XF_SCRUB));
  assign rf_wr_idx  = idx;
  assign rf_wr_data = (kind == XF_LOAD) ? sp_rdata : '0;
  assign state_o    = state;

  vu_event_ctr #(.CW(CW)) u_ctr_saved (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (inc_saved),
    .count (cnt_to_saved)
  );

  vu_event_ctr #(.CW(CW)) u_ctr_dirty (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (inc_dirty),
    .count (cnt_to_dirty)
  );

endmodule

// File: rtl/vu_state_checker.sv
module vu_state_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic [2:0]    ins_class,
  input logic          ins_spec,
  input logic          rf_wr_en,
  input logic          busy,
  input logic [1:0]    state_o,
  input logic [CW-1:0] cnt_to_saved,
  input logic [CW-1:0] cnt_to_dirty
);

  logic acc;
  assign acc = ins_valid && ins_ready;

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (state_o == 2'd0 && !busy && cnt_to_saved == '0 && cnt_to_dirty == '0));

  a_r2_no_clean_to_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |=> (state_o != 2'd2));

  a_r3_dirty_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && acc && !ins_spec && ins_class >= 3'd3 && ins_class <= 3'd5)
      |=> (state_o == 2'd0 && !busy));

  a_r4_park_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && acc && !ins_spec && ins_class == 3'd0)
      |=> (state_o == 2'd2 && busy));

  a_r6_unpark_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && acc && !ins_spec && (ins_class == 3'd1 || ins_class == 3'd2))
      |=> (state_o == 2'd1 && busy && cnt_to_dirty == $past(cnt_to_dirty) + 1'b1));

  a_r8_spec_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ins_spec) |=> ($stable(state_o) && $stable(cnt_to_saved) && $stable(cnt_to_dirty) && !busy));

  a_r9_saved_count_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_to_saved != $past(cnt_to_saved)) |-> (state_o == 2'd2 && $past(state_o) == 2'd1));

  a_r10_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ins_ready);

  a_r11_write_in_copy: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> busy);

endmodule

bind vu_state_ctrl vu_state_checker #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ins_valid    (ins_valid),
  .ins_ready    (ins_ready),
  .ins_class    (ins_class),
  .ins_spec     (ins_spec),
  .rf_wr_en     (rf_wr_en),
  .busy         (busy),
  .state_o      (state_o),
  .cnt_to_saved (cnt_to_saved),
  .cnt_to_dirty (cnt_to_dirty)
);

// File: tb/vu_state_ctrl_bench.sv
module vu_state_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NREG  = 16;
  localparam int UW    = 128;
  localparam int OVH   = 34;
  localparam int CW    = 8;
  localparam int IW    = $clog2(NREG);
  localparam int TOTAL = OVH + NREG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [2:0]    ins_class = 3'd0;
  logic          ins_spec = 1'b0;
  logic [IW-1:0] rf_rd_idx;
  logic [UW-1:0] rf_rd_data;
  logic          rf_wr_en;
  logic [IW-1:0] rf_wr_idx;
  logic [UW-1:0] rf_wr_data;
  logic          busy;
  logic [1:0]    state_o;
  logic [CW-1:0] cnt_to_saved;
  logic [CW-1:0] cnt_to_dirty;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vu_state_ctrl #(.NREG(NREG), .UW(UW), .OVH(OVH), .CW(CW)) u_vu_state_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .ins_ready    (ins_ready),
    .ins_class    (ins_class),
    .ins_spec     (ins_spec),
    .rf_rd_idx    (rf_rd_idx),
    .rf_rd_data   (rf_rd_data),
    .rf_wr_en     (rf_wr_en),
    .rf_wr_idx    (rf_wr_idx),
    .rf_wr_data   (rf_wr_data),
    .busy         (busy),
    .state_o      (state_o),
    .cnt_to_saved (cnt_to_saved),
    .cnt_to_dirty (cnt_to_dirty)
  );

  // register file model
  logic [UW-1:0] rf [NREG];
  logic init_rf  = 1'b0;
  logic scramble = 1'b0;
  int   wr_seq = 0;
  int   wr_order_err = 0;

  function automatic logic [UW-1:0] pat(input int i);
    return {4{32'hC0DE_0000 + 32'(i) * 32'h0001_0101}};
  endfunction

  assign rf_rd_data = rf[rf_rd_idx];

  always @(posedge clk) begin
    if (init_rf) begin
      for (int i = 0; i < NREG; i++) rf[i] <= pat(i);
    end else if (scramble) begin
      for (int i = 0; i < NREG; i++) rf[i] <= ~rf[i];
    end else if (rf_wr_en) begin
      rf[rf_wr_idx] <= rf_wr_data;
      if (int'(rf_wr_idx) != wr_seq) wr_order_err++;
      wr_seq = (wr_seq + 1) % NREG;
    end
  end

  // scoreboard
  typedef struct {
    logic [1:0] st;
    int         stall;
    int         cs;
    int         cd;
    string      tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   stall_meas = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " state"}, int'(state_o), int'(e.st));
        check({e.tag, " stall"}, stall_meas, e.stall);
        check({e.tag, " cnt_to_saved (R9)"}, int'(cnt_to_saved), e.cs);
        check({e.tag, " cnt_to_dirty (R9)"}, int'(cnt_to_dirty), e.cd);
      end
    end
  end

  task automatic issue(input logic [2:0] c, input logic s, input logic [1:0] es,
                       input int est, input int ecs, input int ecd, input string tag);
    exp_t e;
    @(negedge clk);
    ins_valid = 1'b1;
    ins_class = c;
    ins_spec  = s;
    while (!ins_ready) @(negedge clk);
    @(posedge clk);
    #1;
    ins_valid = 1'b0;
    ins_spec  = 1'b0;
    stall_meas = 0;
    @(negedge clk);
    while (busy) begin
      stall_meas++;
      @(negedge clk);
    end
    e.st = es; e.stall = est; e.cs = ecs; e.cd = ecd; e.tag = tag;
    q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int bad;
    init_rf = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 state in reset", int'(state_o), 0);
    check("R1 busy in reset", int'(busy), 0);
    init_rf = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(ins_ready), 1);
    check("R1 counters after reset", int'(cnt_to_saved) + int'(cnt_to_dirty), 0);

    // R2 clean condition
    issue(3'd0, 1'b0, 2'd0, 0, 0, 0, "R2 clean legacy");
    issue(3'd1, 1'b0, 2'd0, 0, 0, 0, "R2 clean pfx narrow");
    issue(3'd3, 1'b0, 2'd0, 0, 0, 0, "R2 clean zero-up");
    issue(3'd5, 1'b0, 2'd0, 0, 0, 0, "R2 clean restore");
    issue(3'd2, 1'b0, 2'd1, 0, 0, 0, "R2 clean pfx wide");

    // R3 dirty condition
    issue(3'd1, 1'b0, 2'd1, 0, 0, 0, "R3 dirty pfx narrow");
    issue(3'd4, 1'b0, 2'd0, 0, 0, 0, "R3 dirty zero-all");
    issue(3'd2, 1'b0, 2'd1, 0, 0, 0, "R3 back to dirty");
    issue(3'd5, 1'b0, 2'd0, 0, 0, 0, "R3 dirty restore");
    issue(3'd2, 1'b0, 2'd1, 0, 0, 0, "R3 dirty again");

    // R8 speculative in dirty
    issue(3'd0, 1'b1, 2'd1, 0, 0, 0, "R8 spec legacy in dirty");

    // R4 park
    issue(3'd0, 1'b0, 2'd2, TOTAL, 1, 0, "R4 dirty legacy park");
    @(negedge clk); scramble = 1'b1;
    @(negedge clk); scramble = 1'b0;

    // R5 and R8 in saved
    issue(3'd0, 1'b0, 2'd2, 0, 1, 0, "R5 saved legacy");
    issue(3'd2, 1'b1, 2'd2, 0, 1, 0, "R8 spec wide in saved");

    // R6 unpark restores data in order
    issue(3'd2, 1'b0, 2'd1, TOTAL, 1, 1, "R6 saved pfx wide unpark");
    bad = 0;
    for (int i = 0; i < NREG; i++) if (rf[i] !== pat(i)) bad++;
    check("R6 restored uppers mismatching", bad, 0);
    check("R6 write order errors", wr_order_err, 0);

    // R7 scrub out of saved
    issue(3'd0, 1'b0, 2'd2, TOTAL, 2, 1, "R4 second park");
    issue(3'd3, 1'b0, 2'd0, TOTAL, 2, 1, "R7 saved zero-up scrub");
    bad = 0;
    for (int i = 0; i < NREG; i++) if (rf[i] !== '0) bad++;
    check("R7 nonzero uppers after scrub", bad, 0);

    // R10 held instruction during copy
    issue(3'd2, 1'b0, 2'd1, 0, 2, 1, "R10 setup dirty");
    @(negedge clk);
    ins_valid = 1'b1;
    ins_class = 3'd0;
    @(posedge clk);
    #1;
    ins_class = 3'd2;
    repeat (10) @(negedge clk);
    check("R10 ready low during copy", int'(ins_ready), 0);
    check("R10 state held saved", int'(state_o), 2);
    check("R10 cnt_to_dirty unchanged", int'(cnt_to_dirty), 1);
    check("R11 no write during save copy", int'(rf_wr_en), 0);
    while (!ins_ready) @(negedge clk);
    @(posedge clk);
    #1;
    ins_valid = 1'b0;
    stall_meas = 0;
    @(negedge clk);
    while (busy) begin
      stall_meas++;
      @(negedge clk);
    end
    check("R10 held unpark stall", stall_meas, TOTAL);
    check("R10 state after held", int'(state_o), 1);
    check("R9 cnt_to_saved final", int'(cnt_to_saved), 3);
    check("R9 cnt_to_dirty final", int'(cnt_to_dirty), 2);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule